// File: doc/BRIEF.md
# MIDI UART Receive Port

This block sits between a byte-level MIDI receiver, a byte-level transmitter and a host register bus. Received bytes go into a small circular FIFO, each stored as a 32-bit word with a valid tag. The bytes are not handed to the host as they arrive. A periodic poll tick moves at most one FIFO entry into a holding register, and the host then reads that register. The host can also read or overwrite any FIFO slot directly, using longword accesses through a paged window.

Bytes that the host writes to the data register go straight to a one-cycle transmit strobe. The FIFO is not involved on the transmit side. Two interrupt flags are derived from the ready bits and the enable fields in the control register. A single interrupt output combines them.

Byte registers, by offset:

- 0x08: data. A read returns the holding byte. A write sends a byte to the transmit strobe.
- 0x09: control when written, status when read.
- 0x0A: reserved.
- 0x0C: page.

Longword window offsets are 0x30, 0x34, 0x38 and 0x3C. Read data is combinational. All side effects take place at the clock edge on which the access is presented.

Top module: `midi_rx_port`

## Requirements
- R1: After reset, the following all read 0: status, the interrupt output, the holding byte, the page register and the reserved register. The FIFO is empty and `tx_valid` is 0.
- R2: A byte on `rx_byte` with `rx_valid` high, when the FIFO is not full, is stored as `{23'b0, 1'b1, byte}` at the write pointer. The write pointer then advances modulo 8.
- R3: The FIFO is full when the write pointer plus one equals the read pointer. In that state an incoming byte is dropped and neither pointer moves. The overflow flag (status bit 3) is set and stays set until a software reset.
- R4: On a poll tick with a non-empty FIFO, bits 7:0 of the entry at the read pointer go to the holding register, the read pointer advances and RXRDY (status bit 0) is set. On a poll tick with an empty FIFO, RXRDY is cleared.
- R5: A byte read at 0x08 returns the holding byte. It also clears RXRDY unless a poll tick occurs in the same cycle.
- R6: When the page register (4 bits, byte write and read at 0x0C) holds 0xE or 0xF, a longword access at 0x30, 0x34, 0x38 or 0x3C reads or writes FIFO entry `{page[0], addr[3:2]}`. Such an access moves no pointer. In any other case, a longword read returns 0.
- R7: A control write at 0x09 keeps only the bits under mask 0xE3. The RX interrupt flag (status bit 7) is `ctrl[7] & RXRDY`. The TX interrupt flag (status bit 2) is set only when `ctrl[6:5]` equals 2'b01 and TXRDY (status bit 1) is set.
- R8: A control write with bits 1:0 equal to 2'b11 is a software reset. It zeroes every FIFO entry and both pointers, clears RXRDY and overflow, and sets TXRDY. Any other control write sets TXRDY.
- R9: A byte write at 0x08 raises `tx_valid` for exactly one cycle, with the byte on `tx_byte`, in the cycle after the write. It also sets TXRDY and leaves the FIFO unchanged.
- R10: `uart_irq` is high exactly when the RX or the TX interrupt flag is set.
- R11: The reserved register at 0x0A stores bit 0 of a write and reads back only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte |
| poll | input | 1 | Poll tick: drain one FIFO entry |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_long | input | 1 | 1 = longword access, 0 = byte access |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 32 | Write data (byte accesses use bits 7:0) |
| bus_rdata | output | 32 | Read data, combinational |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| uart_irq | output | 1 | UART interrupt status |

## Verification
The bench uses the default parameters: a depth of 8 and window pages 0xE and 0xF. With these values the two window pages cover every FIFO slot, so the bench can observe each stored word, its valid tag and the slot a dropped byte would have overwritten. The same depth means the pointers wrap after eight pushes and the FIFO becomes full after seven unread bytes. A directed pass covers wrap, overflow, the control mask codes and software reset. A seeded random mix of pushes, polls, page changes, window writes and control writes then runs against a reference model of the requirements.

// File: rtl/midi_rx_port.sv
module midi_rx_port #(
  parameter int DEPTH = 8,
  parameter logic [3:0] WIN_PAGE = 4'hE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        poll,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_long,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        uart_irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [5:0] A_DATA = 6'h08, A_CTRL = 6'h09, A_RES = 6'h0A, A_PAGE = 6'h0C;
  localparam logic [7:0] CTRL_MASK = 8'hE3;

  logic [31:0]      fifo [DEPTH];
  logic [PTR_W-1:0] rp, wp;
  logic [7:0]       hold, ctrl;
  logic [3:0]       page;
  logic             rxrdy, txrdy, ovf, res;

  wire byte_wr  = bus_wr && !bus_long;
  wire byte_rd  = bus_rd && !bus_long;
  wire data_wr  = byte_wr && bus_addr == A_DATA;
  wire data_rd  = byte_rd && bus_addr == A_DATA;
  wire ctrl_wr  = byte_wr && bus_addr == A_CTRL;
  wire soft_rst = ctrl_wr && bus_wdata[1:0] == 2'b11;
  wire win_hit  = bus_long && page[3:1] == WIN_PAGE[3:1] && bus_addr[5:4] == 2'b11;
  wire [PTR_W-1:0] win_idx = PTR_W'({page[0], bus_addr[3:2]});

  wire fifo_empty = rp == wp;
  wire full       = PTR_W'(wp + 1'b1) == rp;
  wire push_ok    = rx_valid && !full;
  wire pop        = poll && !fifo_empty;

  wire rx_int = ctrl[7] && rxrdy;
  wire tx_int = ctrl[6:5] == 2'b01 && txrdy;
  assign uart_irq = rx_int || tx_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
    end else begin
      if (push_ok) fifo[wp] <= {23'b0, 1'b1, rx_byte};
      if (win_hit && bus_wr) fifo[win_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0;
      wp <= '0;
    end else if (soft_rst) begin
      rp <= '0;
      wp <= '0;
    end else begin
      if (push_ok) wp <= PTR_W'(wp + 1'b1);
      if (pop)     rp <= PTR_W'(rp + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      rxrdy <= 1'b0;
      txrdy <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (pop) hold <= fifo[rp][7:0];
      if (soft_rst)     rxrdy <= 1'b0;
      else if (poll)    rxrdy <= pop;
      else if (data_rd) rxrdy <= 1'b0;
      if (ctrl_wr || data_wr) txrdy <= 1'b1;
      if (soft_rst)               ovf <= 1'b0;
      else if (rx_valid && full)  ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      page     <= '0;
      res      <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (ctrl_wr) ctrl <= bus_wdata[7:0] & CTRL_MASK;
      if (byte_wr && bus_addr == A_PAGE) page <= bus_wdata[3:0];
      if (byte_wr && bus_addr == A_RES)  res  <= bus_wdata[0];
      tx_valid <= data_wr;
      if (data_wr) tx_byte <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_long) begin
      if (win_hit) bus_rdata = fifo[win_idx];
    end else begin
      case (bus_addr)
        A_DATA:  bus_rdata = {24'b0, hold};
        A_CTRL:  bus_rdata = {24'b0, rx_int, 3'b0, ovf, tx_int, txrdy, rxrdy};
        A_RES:   bus_rdata = {31'b0, res};
        A_PAGE:  bus_rdata = {28'b0, page};
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !full && !soft_rst) |=> wp == PTR_W'($past(wp) + 1'b1)); // R2
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !soft_rst) |=> (wp == $past(wp) && ovf)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !soft_rst) |=> ovf); // R3
  AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && fifo_empty) |=> !rxrdy); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !poll) |=> !rxrdy); // R5
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rp == '0 && wp == '0 && !rxrdy && txrdy && !ovf)); // R8
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && txrdy && tx_byte == $past(bus_wdata[7:0]))); // R9
endmodule

// File: tb/midi_rx_port_bench.sv
`timescale 1ns/1ps
module midi_rx_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, poll = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_long = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, uart_irq;
  logic [7:0] tx_byte;

  midi_rx_port u_midi_rx_port (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .poll(poll),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_long(bus_long), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .uart_irq(uart_irq)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_fifo [8];
  logic [2:0]  m_rp = 0, m_wp = 0;
  logic [7:0]  m_hold = 0, m_ctrl = 0;
  logic [3:0]  m_page = 0;
  logic        m_rxrdy = 0, m_txrdy = 0, m_ovf = 0, m_res = 0;

  function automatic logic m_rxint(); return m_ctrl[7] && m_rxrdy; endfunction
  function automatic logic m_txint(); return m_ctrl[6:5] == 2'b01 && m_txrdy; endfunction
  function automatic logic [31:0] m_status();
    return {24'b0, m_rxint(), 3'b0, m_ovf, m_txint(), m_txrdy, m_rxrdy};
  endfunction
  function automatic logic m_win(logic [5:0] a);
    return m_page[3:1] == 3'b111 && a[5:4] == 2'b11;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_push(logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    if (3'(m_wp + 1) == m_rp) m_ovf = 1;
    else begin m_fifo[m_wp] = {23'b0, 1'b1, b}; m_wp = m_wp + 1; end
  endtask

  task automatic do_poll();
    poll = 1;
    @(negedge clk); poll = 0;
    if (m_rp != m_wp) begin m_hold = m_fifo[m_rp][7:0]; m_rp = m_rp + 1; m_rxrdy = 1; end
    else m_rxrdy = 0;
  endtask

  task automatic rd_byte(logic [5:0] a, output logic [31:0] d);
    bus_rd = 1; bus_long = 0; bus_addr = a; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0;
    if (a == 6'h08) m_rxrdy = 0;
  endtask

  task automatic wr_byte(logic [5:0] a, logic [7:0] v);
    bus_wr = 1; bus_long = 0; bus_addr = a; bus_wdata = {24'b0, v};
    @(negedge clk); bus_wr = 0;
    case (a)
      6'h08: m_txrdy = 1;
      6'h09: begin
        m_ctrl = v & 8'hE3; m_txrdy = 1;
        if (v[1:0] == 2'b11) begin
          for (int i = 0; i < 8; i++) m_fifo[i] = 0;
          m_rp = 0; m_wp = 0; m_rxrdy = 0; m_ovf = 0;
        end
      end
      6'h0A: m_res = v[0];
      6'h0C: m_page = v[3:0];
      default: ;
    endcase
  endtask

  task automatic rd_long(logic [5:0] a, output logic [31:0] d);
    bus_rd = 1; bus_long = 1; bus_addr = a; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_long = 0;
  endtask

  task automatic wr_long(logic [5:0] a, logic [31:0] v);
    bus_wr = 1; bus_long = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0; bus_long = 0;
    if (m_win(a)) m_fifo[{m_page[0], a[3:2]}] = v;
  endtask

  task automatic chk_status(string req);
    logic [31:0] d;
    rd_byte(6'h09, d);
    chk(req, d, m_status());
    chk({req, " R10 irq"}, {31'b0, uart_irq}, {31'b0, m_rxint() || m_txint()});
  endtask

  task automatic chk_entry(string req, int idx);
    logic [31:0] d;
    wr_byte(6'h0C, 8'hE | (idx >> 2));
    rd_long(6'h30 + 6'((idx & 3) * 4), d);
    chk(req, d, m_fifo[idx]);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin checks++; fails++; $display("FAIL watchdog: actual hung expected done"); report(); end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 8; i++) m_fifo[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, uart_irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    rd_byte(6'h09, d); chk("R1 status", d, 0);
    rd_byte(6'h08, d); chk("R1 hold", d, 0);
    rd_byte(6'h0C, d); chk("R1 page", d, 0);
    rd_byte(6'h0A, d); chk("R1 reserved", d, 0);

    // R2 / R6 pushes visible through window
    wr_byte(6'h0C, 8'h0E);
    rd_byte(6'h0C, d); chk("R6 page readback", d, 32'hE);
    do_push(8'h11); do_push(8'h22); do_push(8'h33);
    rd_long(6'h30, d); chk("R2 entry0", d, 32'h111);
    rd_long(6'h38, d); chk("R2 entry2", d, 32'h133);
    rd_long(6'h3C, d); chk("R2 entry3 empty", d, 0);

    // R4 / R5 poll then read
    do_poll(); chk_status("R4 rxrdy set");
    rd_byte(6'h08, d); chk("R5 hold byte", d, 32'h11);
    chk_status("R5 rxrdy cleared");
    do_poll(); do_poll();
    rd_byte(6'h08, d); chk("R4 third byte", d, 32'h33);
    do_poll(); chk_status("R4 empty poll clears");

    // R3 full and drop, R2 wrap
    for (int i = 0; i < 7; i++) do_push(8'hA0 + 8'(i));
    chk_status("R3 no overflow at 7");
    do_push(8'hEE);
    chk_status("R3 overflow flag");
    chk_entry("R3 dropped slot unchanged", 2);
    chk_entry("R2 wrapped entry0", 0);
    chk_entry("R2 entry7", 7);

    // R6 window write then drain
    wr_byte(6'h0C, 8'h0F);
    wr_long(6'h34, 32'hABCD_01FF);
    rd_long(6'h34, d); chk("R6 window write", d, 32'hABCD_01FF);
    do_poll(); do_poll(); do_poll();
    rd_byte(6'h08, d); chk("R6 written entry drained", d, 32'hFF);
    wr_byte(6'h0C, 8'h05);
    rd_long(6'h30, d); chk("R6 off page reads 0", d, 0);
    do_push(8'h77); chk_status("R3 overflow sticky");

    // R7 / R10 interrupt fields
    wr_byte(6'h09, 8'h80); do_poll(); chk_status("R7 rx int");
    chk("R10 irq rx", {31'b0, uart_irq}, 1);
    rd_byte(6'h08, d); chk_status("R7 rx int drops");
    wr_byte(6'h09, 8'h20); chk_status("R7 tx code 01");
    wr_byte(6'h09, 8'h40); chk_status("R7 tx code 10");
    wr_byte(6'h09, 8'h60); chk_status("R7 tx code 11");
    wr_byte(6'h09, 8'h3C); chk_status("R7 mask keeps code 01");

    // R9 transmit
    wr_byte(6'h08, 8'h5A);
    chk("R9 tx_valid", {31'b0, tx_valid}, 1);
    chk("R9 tx_byte", {24'b0, tx_byte}, 32'h5A);
    @(negedge clk);
    chk("R9 single pulse", {31'b0, tx_valid}, 0);
    chk_status("R9 fifo untouched");

    // R8 software reset
    wr_byte(6'h09, 8'h03);
    chk_status("R8 soft reset status");
    chk_entry("R8 entry zeroed", 5);
    do_poll(); chk_status("R8 empty after reset");

    // R11 reserved
    wr_byte(6'h0A, 8'hFF); rd_byte(6'h0A, d); chk("R11 bit0 only", d, 1);
    wr_byte(6'h0A, 8'hFE); rd_byte(6'h0A, d); chk("R11 cleared", d, 0);

    // random mix against model
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: do_push(8'($urandom));
        3, 4: do_poll();
        5: begin rd_byte(6'h08, d); chk("R5 random read", d, {24'b0, m_hold}); end
        6: begin
          logic [7:0] c;
          c = 8'($urandom);
          if ($urandom_range(0, 3) != 0) c[1:0] = 2'b00;
          wr_byte(6'h09, c);
        end
        7: wr_byte(6'h0C, 8'($urandom_range(13, 15)));
        8: begin
          logic [5:0] a;
          a = 6'h30 + 6'($urandom_range(0, 3) * 4);
          rd_long(a, d);
          chk("R6 random window", d, m_win(a) ? m_fifo[{m_page[0], a[3:2]}] : 32'h0);
        end
        default: if ($urandom_range(0, 1) == 0) wr_byte(6'h08, 8'($urandom));
                 else wr_long(6'h30 + 6'($urandom_range(0, 3) * 4), $urandom);
      endcase
      chk_status("R7 random status");
    end

    done = 1;
    report();
  end
endmodule